// File: doc/BRIEF.md
# Seed Word Mutation Matcher

This block scans a stream of database symbols for short seed words. Software first fills a table of candidate words: an original four-symbol seed taken from a query and the likely mutated forms of it. The engine then takes one database symbol per cycle. It keeps the last four symbols as a window and compares that window with every table entry at once, at every position of the stream.

Each position whose window equals a valid entry produces one hit. A hit carries the stream position of the window's first symbol, the index of the matching entry and a flag that is set when more than one entry matched there. Hits wait in a small FIFO until a downstream extension unit takes them. While the FIFO is full the engine stops accepting symbols, so no position is skipped and no hit is dropped.

Top module: `seed_match_engine`

## Requirements
- R1: After reset the hit output is empty (hit_valid low), the table holds no valid entry and sym_ready is high.
- R2: A load cycle (load_en high) writes load_word and load_valid into entry load_idx. An entry whose valid bit is clear never produces a hit.
- R3: A symbol marked with sym_first starts a new sequence at position 0. No hit is produced until four symbols of the current sequence have been accepted, and a window never spans a sequence start.
- R4: Every accepted symbol from the fourth onward forms one window, and each window is compared against all entries. A window is packed with its oldest symbol in bits 19:15 and its newest in bits 4:0; hit_pos is the position of the oldest symbol, counting from 0 at the sequence start.
- R5: When several entries match one window, hit_idx is the lowest matching index and hit_multi is 1; with exactly one match hit_multi is 0.
- R6: Hits leave in the order their windows were accepted. A hit is visible on the outputs the cycle after its fourth symbol is accepted if the FIFO held nothing before. The FIFO holds eight hits.
- R7: While the FIFO holds eight hits sym_ready is low and no symbol is accepted; the stream resumes without losing a position or a hit.
- R8: The head hit is removed only in a cycle where hit_valid and hit_pop are both high; otherwise it stays on the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write one table entry this cycle |
| load_idx | input | 6 | Index of the entry written |
| load_word | input | 20 | Four packed 5-bit symbols, oldest in 19:15 |
| load_valid | input | 1 | Valid bit stored with the entry |
| sym_valid | input | 1 | A database symbol is offered |
| sym_data | input | 5 | The offered symbol |
| sym_first | input | 1 | The offered symbol begins a new sequence |
| sym_ready | output | 1 | The engine accepts a symbol this cycle |
| hit_valid | output | 1 | A hit is waiting at the FIFO head |
| hit_pos | output | 32 | Position of the oldest symbol of the matching window |
| hit_idx | output | 6 | Lowest matching table index |
| hit_multi | output | 1 | More than one entry matched that window |
| hit_pop | input | 1 | Consume the head hit |

## Verification
The bench goes after the window boundaries: a design that reported a hit after three symbols, or let a window straddle a sequence start, would surface a hit that the expected queue does not hold. Duplicate entries expose a wrong priority encoder as a higher index or a missing multi flag, and entries loaded with a clear valid bit expose a comparator that ignores validity. Filling the FIFO with no pops catches a design that keeps accepting when full, which would drop a hit or shift every later position, and a long random run over a four-symbol alphabet checks that positions, order and one-cycle hit latency hold under mixed stalls and pops.

// File: rtl/seed_match_pkg.sv
`timescale 1ns/1ps
package seed_match_pkg;
    localparam int unsigned DEF_SYM_W      = 5;
    localparam int unsigned DEF_SEED_LEN   = 4;
    localparam int unsigned DEF_ENTRIES    = 64;
    localparam int unsigned DEF_POS_W      = 32;
    localparam int unsigned DEF_FIFO_DEPTH = 8;
endpackage

// File: rtl/seed_table.sv
`timescale 1ns/1ps
module seed_table #(
    parameter int unsigned SYM_W    = 5,
    parameter int unsigned SEED_LEN = 4,
    parameter int unsigned ENTRIES  = 64,
    localparam int unsigned WORD_W  = SYM_W * SEED_LEN,
    localparam int unsigned IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] probe_word,
    output logic              any_hit,
    output logic [IDX_W-1:0]  first_idx,
    output logic              multi_hit
);
    typedef struct packed {
        logic [ENTRIES-1:0][WORD_W-1:0] word;
        logic [ENTRIES-1:0]             valid;
    } table_t;

    table_t tbl_d, tbl_q;
    logic [ENTRIES-1:0] match;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d.word[wr_idx]  = wr_word;
            tbl_d.valid[wr_idx] = wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = tbl_q.valid[g] && (tbl_q.word[g] == probe_word);
    end

    always_comb begin
        first_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) first_idx = IDX_W'(i);
        end
        any_hit   = |match;
        multi_hit = (match & (match - 1'b1)) != '0;
    end
endmodule

// File: rtl/hit_fifo.sv
`timescale 1ns/1ps
module hit_fifo #(
    parameter int unsigned DATA_W = 39,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [CNT_W-1:0]  count
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = bump(st_q.wr);
        end
        if (do_pop) st_d.rd = bump(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.cnt != '0;
    assign out_data  = st_q.mem[st_q.rd];
    assign count     = st_q.cnt;
endmodule

// File: rtl/seed_match_engine.sv
`timescale 1ns/1ps
module seed_match_engine import seed_match_pkg::*; #(
    parameter int unsigned SYM_W      = DEF_SYM_W,
    parameter int unsigned SEED_LEN   = DEF_SEED_LEN,
    parameter int unsigned ENTRIES    = DEF_ENTRIES,
    parameter int unsigned POS_W      = DEF_POS_W,
    parameter int unsigned FIFO_DEPTH = DEF_FIFO_DEPTH,
    localparam int unsigned WORD_W    = SYM_W * SEED_LEN,
    localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [WORD_W-1:0] load_word,
    input  logic              load_valid,
    input  logic              sym_valid,
    input  logic [SYM_W-1:0]  sym_data,
    input  logic              sym_first,
    output logic              sym_ready,
    output logic              hit_valid,
    output logic [POS_W-1:0]  hit_pos,
    output logic [IDX_W-1:0]  hit_idx,
    output logic              hit_multi,
    input  logic              hit_pop
);
    localparam int unsigned FILL_W = $clog2(SEED_LEN);
    localparam int unsigned HIT_W  = POS_W + IDX_W + 1;
    localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic [WORD_W-1:0] win;
        logic [FILL_W-1:0] fill;
        logic [POS_W-1:0]  pos;
    } stream_t;

    stream_t           st_d, st_q;
    logic              accept, window_full, hit_push;
    logic [POS_W-1:0]  base_pos;
    logic [FILL_W-1:0] base_fill;
    logic [WORD_W-1:0] next_win;
    logic              tbl_any, tbl_multi;
    logic [IDX_W-1:0]  tbl_idx;
    logic [HIT_W-1:0]  push_data, head_data;
    logic [CNT_W-1:0]  fifo_count;

    assign sym_ready = fifo_count != CNT_W'(FIFO_DEPTH);

    always_comb begin
        st_d        = st_q;
        accept      = sym_valid && sym_ready;
        base_pos    = sym_first ? '0 : st_q.pos;
        base_fill   = sym_first ? '0 : st_q.fill;
        next_win    = {st_q.win[WORD_W-SYM_W-1:0], sym_data};
        window_full = base_fill == FILL_W'(SEED_LEN - 1);
        hit_push    = accept && window_full && tbl_any;
        push_data   = {base_pos - POS_W'(SEED_LEN - 1), tbl_idx, tbl_multi};
        if (accept) begin
            st_d.win  = next_win;
            st_d.fill = window_full ? base_fill : base_fill + 1'b1;
            st_d.pos  = base_pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    seed_table #(
        .SYM_W(SYM_W), .SEED_LEN(SEED_LEN), .ENTRIES(ENTRIES)
    ) i_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(load_en), .wr_idx(load_idx), .wr_word(load_word), .wr_valid(load_valid),
        .probe_word(next_win),
        .any_hit(tbl_any), .first_idx(tbl_idx), .multi_hit(tbl_multi)
    );

    hit_fifo #(
        .DATA_W(HIT_W), .DEPTH(FIFO_DEPTH)
    ) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(hit_push), .push_data(push_data),
        .pop(hit_pop),
        .out_valid(hit_valid), .out_data(head_data), .count(fifo_count)
    );

    assign {hit_pos, hit_idx, hit_multi} = head_data;
endmodule

// File: rtl/seed_match_checker.sv
`timescale 1ns/1ps
module seed_match_checker #(
    parameter int unsigned POS_W = 32,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic             sym_first,
    input logic             sym_ready,
    input logic             hit_valid,
    input logic             hit_pop,
    input logic [POS_W-1:0] hit_pos,
    input logic [IDX_W-1:0] hit_idx,
    input logic             hit_push,
    input logic [CNT_W-1:0] fifo_count
);
    p_full_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count == CNT_W'(DEPTH) |-> !sym_ready);

    p_push_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_push |-> fifo_count != CNT_W'(DEPTH));

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid && !hit_pop |=> hit_valid && $stable(hit_pos) && $stable(hit_idx));

    p_first_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && sym_ready && sym_first |-> !hit_push);
endmodule

bind seed_match_engine seed_match_checker #(
    .POS_W(POS_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)
) i_checker (
    .clk(clk), .rst_n(rst_n),
    .sym_valid(sym_valid), .sym_first(sym_first), .sym_ready(sym_ready),
    .hit_valid(hit_valid), .hit_pop(hit_pop), .hit_pos(hit_pos), .hit_idx(hit_idx),
    .hit_push(hit_push), .fifo_count(fifo_count)
);

// File: tb/test_seed_match_engine.sv
`timescale 1ns/1ps
module test_seed_match_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [5:0]  load_idx = '0;
    logic [19:0] load_word = '0;
    logic        load_valid = 1'b0;
    logic        sym_valid = 1'b0;
    logic [4:0]  sym_data = '0;
    logic        sym_first = 1'b0;
    logic        sym_ready;
    logic        hit_valid;
    logic [31:0] hit_pos;
    logic [5:0]  hit_idx;
    logic        hit_multi;
    logic        hit_pop = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [19:0] m_word [64];
    bit          m_val  [64];
    logic [19:0] m_win = '0;
    int          m_fill = 0;
    logic [31:0] m_pos = '0;
    logic [38:0] exp_q [$];

    always #2.5 clk = ~clk;

    seed_match_engine i_seed_match_engine (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .load_idx(load_idx), .load_word(load_word), .load_valid(load_valid),
        .sym_valid(sym_valid), .sym_data(sym_data), .sym_first(sym_first), .sym_ready(sym_ready),
        .hit_valid(hit_valid), .hit_pos(hit_pos), .hit_idx(hit_idx), .hit_multi(hit_multi),
        .hit_pop(hit_pop)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] pack4(input int a, input int b, input int c, input int d);
        return {a[4:0], b[4:0], c[4:0], d[4:0]};
    endfunction

    // expected hit for one accepted symbol, from the requirements (R3 R4 R5)
    task automatic model_accept(input logic [4:0] s, input bit first);
        int          bf;
        logic [31:0] bp;
        int          n_match;
        int          lo;
        bf = first ? 0 : m_fill;
        bp = first ? 32'd0 : m_pos;
        m_win = {m_win[14:0], s};
        if (bf == 3) begin
            n_match = 0;
            lo = 0;
            for (int i = 63; i >= 0; i--) begin
                if (m_val[i] && m_word[i] == m_win) begin
                    n_match++;
                    lo = i;
                end
            end
            if (n_match > 0) exp_q.push_back({bp - 32'd3, lo[5:0], n_match > 1});
        end
        m_fill = (bf == 3) ? 3 : bf + 1;
        m_pos = bp + 32'd1;
    endtask

    task automatic load_entry(input int idx, input logic [19:0] w, input bit v);
        load_en = 1'b1; load_idx = idx[5:0]; load_word = w; load_valid = v;
        m_word[idx] = w; m_val[idx] = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // one cycle of stimulus plus scoreboard; called at a falling edge
    task automatic step(input bit v, input logic [4:0] s, input bit f, input bit p);
        logic [38:0] e;
        sym_valid = v; sym_data = s; sym_first = f; hit_pop = p;
        check(hit_valid == (exp_q.size() != 0), "R6 hit visibility", 64'(hit_valid), 64'(exp_q.size() != 0));
        if (hit_valid && p && exp_q.size() != 0) begin
            e = exp_q.pop_front();
            check({hit_pos, hit_idx, hit_multi} == e, "R4/R5/R6 hit contents",
                  64'({hit_pos, hit_idx, hit_multi}), 64'(e));
        end
        if (v && sym_ready) model_accept(s, f);
        @(negedge clk);
        sym_valid = 1'b0; sym_first = 1'b0; hit_pop = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 64) begin
            step(1'b0, 5'd0, 1'b0, 1'b1);
            guard++;
        end
        step(1'b0, 5'd0, 1'b0, 1'b1);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) begin m_word[i] = '0; m_val[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(hit_valid == 1'b0, "R1 hit_valid after reset", 64'(hit_valid), 0);
        check(sym_ready == 1'b1, "R1 sym_ready after reset", 64'(sym_ready), 1);
        step(1'b1, 5'd0, 1'b1, 1'b0);
        step(1'b1, 5'd0, 1'b0, 1'b0);
        step(1'b1, 5'd0, 1'b0, 1'b0);
        step(1'b1, 5'd0, 1'b0, 1'b0);
        check(hit_valid == 1'b0, "R1 empty table gives no hit", 64'(hit_valid), 0);

        // R5 duplicate entries, R4 window order, R3 first hit timing
        load_entry(9, pack4(1, 2, 3, 4), 1'b1);
        load_entry(5, pack4(1, 2, 3, 4), 1'b1);
        load_entry(2, pack4(4, 3, 2, 1), 1'b1);
        load_entry(3, pack4(2, 3, 4, 9), 1'b1);
        step(1'b1, 5'd1, 1'b1, 1'b0);
        step(1'b1, 5'd2, 1'b0, 1'b0);
        step(1'b1, 5'd3, 1'b0, 1'b0);
        check(hit_valid == 1'b0, "R3 no hit before fourth symbol", 64'(hit_valid), 0);
        step(1'b1, 5'd4, 1'b0, 1'b0);
        check(hit_valid == 1'b1, "R6 hit one cycle after fourth symbol", 64'(hit_valid), 1);
        check(hit_pos == 32'd0, "R4 position of first window", 64'(hit_pos), 0);
        check(hit_idx == 6'd5, "R5 lowest index wins", 64'(hit_idx), 5);
        check(hit_multi == 1'b1, "R5 multi flag", 64'(hit_multi), 1);
        step(1'b1, 5'd9, 1'b0, 1'b0);
        drain();

        // R3 a window never spans a sequence start
        step(1'b1, 5'd1, 1'b1, 1'b0);
        step(1'b1, 5'd2, 1'b0, 1'b0);
        step(1'b1, 5'd3, 1'b1, 1'b0);
        step(1'b1, 5'd4, 1'b0, 1'b0);
        check(hit_valid == 1'b0, "R3 sequence start breaks the window", 64'(hit_valid), 0);

        // R2 entries with a clear valid bit never hit
        load_entry(5, pack4(1, 2, 3, 4), 1'b0);
        load_entry(9, pack4(1, 2, 3, 4), 1'b0);
        step(1'b1, 5'd1, 1'b1, 1'b0);
        step(1'b1, 5'd2, 1'b0, 1'b0);
        step(1'b1, 5'd3, 1'b0, 1'b0);
        step(1'b1, 5'd4, 1'b0, 1'b0);
        check(hit_valid == 1'b0, "R2 invalid entries ignored", 64'(hit_valid), 0);
        load_entry(9, pack4(1, 2, 3, 4), 1'b1);
        step(1'b1, 5'd1, 1'b1, 1'b0);
        step(1'b1, 5'd2, 1'b0, 1'b0);
        step(1'b1, 5'd3, 1'b0, 1'b0);
        step(1'b1, 5'd4, 1'b0, 1'b0);
        check(hit_idx == 6'd9 && hit_multi == 1'b0, "R2/R5 single valid match",
              64'({hit_idx, hit_multi}), 64'({6'd9, 1'b0}));
        drain();

        // R7 stall on full FIFO, R8 head held without pop
        load_entry(0, pack4(7, 7, 7, 7), 1'b1);
        step(1'b1, 5'd7, 1'b1, 1'b0);
        for (int k = 0; k < 12; k++) step(1'b1, 5'd7, 1'b0, 1'b0);
        check(sym_ready == 1'b0, "R7 ready low when full", 64'(sym_ready), 0);
        check(hit_pos == 32'd0, "R8 head kept without pop", 64'(hit_pos), 0);
        check(exp_q.size() == 8, "R7 eight hits held", 64'(exp_q.size()), 8);
        for (int k = 0; k < 6; k++) step(1'b1, 5'd7, 1'b0, 1'b1);
        drain();
        check(hit_valid == 1'b0, "R7 all hits delivered", 64'(hit_valid), 0);

        // random phase over a four-symbol alphabet
        for (int i = 0; i < 64; i++)
            load_entry(i, pack4($urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(3)),
                       $urandom_range(9) < 7);
        for (int k = 0; k < 4000; k++) begin
            if (k % 1000 == 999)
                load_entry($urandom_range(63),
                           pack4($urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(3)),
                           $urandom_range(1) == 1);
            step($urandom_range(9) < 8, 5'($urandom_range(3)), $urandom_range(99) < 2,
                 $urandom_range(9) < ((k / 500) % 2 == 0 ? 6 : 2));
        end
        drain();
        check(hit_valid == 1'b0 && exp_q.size() == 0, "R6 no missing or extra hits",
              64'(hit_valid), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule